// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This unit is the last stage of a double-precision datapath. It takes a sign, a signed unbiased exponent and a 56-bit significand, and turns them into a finished 64-bit binary64 word with overflow, underflow and inexact flags. The significand holds the integer (hidden) bit at bit 55, 52 fraction bits below it, and three extension bits (guard, round, sticky) at bits 2..0. A normalized input has bit 55 set. An input of all-zero significand is outside the contract.

Each operation is a one-cycle pulse on `valid_i`. The result and the flags are registered and appear with `valid_o` one clock later. Tiny operands are denormalized with a sticky right shift and then rounded. A rounding carry renormalizes the significand. Exponents past the top of the range saturate to infinity or to the largest finite value, depending on direction and sign. When flush mode is on, operands below the minimum exponent are replaced outright. Rounding mode encoding: 0 = to nearest, ties to even; 1 = toward zero; 2 = toward +infinity; 3 = toward -infinity.

Top module: `dp_round_pack`

## Requirements
- R1: `valid_o` is high exactly one cycle after each cycle in which `valid_i` is high, and low otherwise. While reset is asserted, `valid_o`, `result_o` and all flags are 0.
- R2: When the exponent lies in [-1022, 1023] and bits 2..0 are zero, the result is exact. The output is sign at bit 63, exponent+1023 in bits 62..52, significand bits 54..3 in bits 51..0, with no flag raised.
- R3: Round to nearest (mode 0) applies only when bits 2..0 are nonzero. It adds 3 plus significand bit 3, which breaks ties toward an even result.
- R4: Mode 1 truncates. Mode 2 adds 8 (one unit in bit 3) only for sign 0. Mode 3 adds 8 only for sign 1. In each case rounding applies only when bits 2..0 are nonzero.
- R5: If rounding carries out of bit 55, the significand shifts right by one and the exponent rises by one.
- R6: If the exponent after rounding exceeds 1023, `ovf_o` and `inx_o` are set. The magnitude is infinity (0x7FF0000000000000 without sign) for mode 0, for mode 2 with sign 0, and for mode 3 with sign 1. In every other case it is the largest finite value (0x7FEFFFFFFFFFFFFF without sign).
- R7: With `flush_den_i` high and the exponent below -1022, `unf_o` and `inx_o` are set. The result is a zero of the input sign, except in two cases: mode 2 with sign 0 gives 0x0000000000000001, and mode 3 with sign 1 gives 0x8000000000000001.
- R8: Without flush, an exponent below -1022 shifts the significand right by (-1022 - exponent). Every bit shifted out is ORed into bit 0, and shifts of 56 or more leave only that sticky bit. The exponent then becomes -1022.
- R9: If the exponent is exactly -1023 and rounding the unshifted significand carries out of bit 55, the result is the smallest normal value of that sign (exponent field 1, fraction 0). Only `inx_o` is set.
- R10: An inexact result whose significand has bit 55 clear before rounding sets `unf_o`. A result encoded as a denormal (bit 55 clear after rounding, exponent field 0) also sets `unf_o` when `uf_trap_en_i` is high. It does not set `unf_o` when `uf_trap_en_i` is low and the result is exact.
- R11: `inx_o` is set whenever any discarded bit was nonzero, and on every overflow or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One-cycle operation strobe |
| sign_i | input | 1 | Sign of the operand |
| exp_i | input | 16 | Signed unbiased exponent |
| sig_i | input | 56 | Significand: hidden bit 55, fraction 54..3, extension 2..0 |
| rmode_i | input | 2 | Rounding mode (0 nearest, 1 zero, 2 up, 3 down) |
| flush_den_i | input | 1 | Flush tiny operands instead of denormalizing |
| uf_trap_en_i | input | 1 | Underflow trap enable |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 64 | Packed binary64 result |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |

## Verification
The unit has a single register stage, so the result word, all three flags and `valid_o` are due at the first rising edge after the edge that samples `valid_i`. None of them is due earlier or later. The bench changes inputs on falling edges, holds the strobe for one cycle, and compares everything on the falling edge that follows the result edge. It also confirms that `valid_o` has dropped again by one idle cycle later.

// File: rtl/dp_pack_pkg.sv
package dp_pack_pkg;
  localparam int PK_FRAC_W = 52;
  localparam int PK_EXPF_W = 11;
  localparam int PK_EXT_W  = 3;
  localparam int PK_EXPI_W = 16;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;
endpackage

// File: rtl/dp_sticky_shr.sv
module dp_sticky_shr #(
  parameter int W  = 56,
  parameter int AW = 18
) (
  input  logic [W-1:0]  m_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  m_o
);
  logic [W-1:0] lost_mask;
  logic         sticky;

  always_comb begin
    if (amt_i >= AW'(W)) begin
      lost_mask = '1;
      sticky    = |m_i;
      m_o       = {{(W-1){1'b0}}, sticky};
    end else begin
      lost_mask = ~({W{1'b1}} << amt_i);
      sticky    = |(m_i & lost_mask);
      m_o       = (m_i >> amt_i) | {{(W-1){1'b0}}, sticky};
    end
  end
endmodule

// File: rtl/dp_round_inc.sv
module dp_round_inc
  import dp_pack_pkg::*;
#(
  parameter int W     = 56,
  parameter int EXT_W = 3
) (
  input  logic [W-1:0] m_i,
  input  logic         sign_i,
  input  logic [1:0]   rmode_i,
  output logic [W:0]   m_o,
  output logic         inexact_o
);
  localparam int WP = W + 1;
  localparam logic [W:0] HALF_M1 = WP'((1 << (EXT_W - 1)) - 1);
  localparam logic [W:0] ULP     = WP'(1 << EXT_W);

  logic [W:0] incr;

  always_comb begin
    inexact_o = |m_i[EXT_W-1:0];
    incr      = '0;
    unique case (rmode_e'(rmode_i))
      RM_NEAR: incr = HALF_M1 + WP'(m_i[EXT_W]);
      RM_ZERO: incr = '0;
      RM_UP:   if (!sign_i) incr = ULP;
      RM_DOWN: if (sign_i)  incr = ULP;
      default: incr = '0;
    endcase
    m_o = {1'b0, m_i} + (inexact_o ? incr : '0);
  end
endmodule

// File: rtl/dp_sat_sel.sv
module dp_sat_sel
  import dp_pack_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXPF_W = 11,
  parameter bit FLUSH  = 1'b0
) (
  input  logic                     sign_i,
  input  logic [1:0]               rmode_i,
  output logic [FRAC_W+EXPF_W:0]   word_o
);
  localparam int MAG_W = FRAC_W + EXPF_W;
  localparam logic [MAG_W-1:0] MAG_INF  = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAG_MAX  = {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  localparam logic [MAG_W-1:0] MAG_TINY = MAG_W'(1);

  logic [MAG_W-1:0] mag;
  logic             away;

  // direction pointing away from zero for this sign
  always_comb begin
    away = (rmode_e'(rmode_i) == RM_UP   && !sign_i) ||
           (rmode_e'(rmode_i) == RM_DOWN &&  sign_i);
  end

  generate
    if (FLUSH) begin : g_flush
      always_comb mag = away ? MAG_TINY : '0;
    end else begin : g_ovf
      always_comb mag = (away || rmode_e'(rmode_i) == RM_NEAR) ? MAG_INF : MAG_MAX;
    end
  endgenerate

  assign word_o = {sign_i, mag};
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
  import dp_pack_pkg::*;
#(
  parameter int FRAC_W = PK_FRAC_W,
  parameter int EXPF_W = PK_EXPF_W,
  parameter int EXT_W  = PK_EXT_W,
  parameter int EXPI_W = PK_EXPI_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic                             sign_i,
  input  logic signed [EXPI_W-1:0]         exp_i,
  input  logic [FRAC_W+EXT_W:0]            sig_i,
  input  logic [1:0]                       rmode_i,
  input  logic                             flush_den_i,
  input  logic                             uf_trap_en_i,
  output logic                             valid_o,
  output logic [FRAC_W+EXPF_W:0]           result_o,
  output logic                             ovf_o,
  output logic                             unf_o,
  output logic                             inx_o
);
  localparam int SIG_W  = FRAC_W + 1 + EXT_W;
  localparam int WORD_W = FRAC_W + EXPF_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EW     = EXPI_W + 2;
  localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
  localparam logic signed [EW-1:0] EMIN_E = EW'(1 - BIAS);
  localparam logic signed [EW-1:0] EMAX_E = EW'(BIAS);
  localparam logic signed [EW-1:0] EDGE_E = EW'(-BIAS);
  localparam logic signed [EW-1:0] BIAS_E = EW'(BIAS);

  logic signed [EW-1:0] e_in, e1, e2;
  logic [EW-1:0]        shift_amt;
  logic                 tiny_in, edge_carry;
  logic [SIG_W-1:0]     m_shift, m1, m2;
  logic [SIG_W:0]       rnd_a, rnd_b;
  logic                 inx_a_unused, inx1, ext_nz_b;
  logic [MANT_W-1:0]    mant;
  logic [WORD_W-1:0]    word_ovf, word_flush, word_d;
  logic                 ovf_d, unf_d, inx_d;

  assign e_in      = {{(EW-EXPI_W){exp_i[EXPI_W-1]}}, exp_i};
  assign tiny_in   = e_in < EMIN_E;
  assign shift_amt = EMIN_E - e_in;

  dp_sticky_shr #(.W(SIG_W), .AW(EW)) i_shr (
    .m_i(sig_i), .amt_i(shift_amt), .m_o(m_shift)
  );

  // trial rounding of the raw significand for the one-below-minimum case
  dp_round_inc #(.W(SIG_W), .EXT_W(EXT_W)) i_rnd_edge (
    .m_i(sig_i), .sign_i(sign_i), .rmode_i(rmode_i),
    .m_o(rnd_a), .inexact_o(inx_a_unused)
  );

  assign edge_carry = (e_in == EDGE_E) && rnd_a[SIG_W];

  always_comb begin
    inx1 = 1'b0;
    if (tiny_in && edge_carry) begin
      m1 = rnd_a[SIG_W:1];
      m1[EXT_W-1:0] = '0;
      e1 = EMIN_E;
      inx1 = 1'b1;
    end else if (tiny_in) begin
      m1 = m_shift;
      e1 = EMIN_E;
    end else begin
      m1 = sig_i;
      e1 = e_in;
    end
  end

  dp_round_inc #(.W(SIG_W), .EXT_W(EXT_W)) i_rnd_main (
    .m_i(m1), .sign_i(sign_i), .rmode_i(rmode_i),
    .m_o(rnd_b), .inexact_o(ext_nz_b)
  );

  always_comb begin
    if (rnd_b[SIG_W]) begin
      m2 = rnd_b[SIG_W:1];
      e2 = e1 + EW'(1);
    end else begin
      m2 = rnd_b[SIG_W-1:0];
      e2 = e1;
    end
    mant = m2[SIG_W-1:EXT_W];
  end

  dp_sat_sel #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .FLUSH(1'b0)) i_sat_ovf (
    .sign_i(sign_i), .rmode_i(rmode_i), .word_o(word_ovf)
  );

  dp_sat_sel #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .FLUSH(1'b1)) i_sat_flush (
    .sign_i(sign_i), .rmode_i(rmode_i), .word_o(word_flush)
  );

  always_comb begin
    ovf_d = 1'b0;
    unf_d = ext_nz_b && !m1[SIG_W-1];
    inx_d = inx1 || ext_nz_b;
    if (flush_den_i && tiny_in) begin
      word_d = word_flush;
      unf_d  = 1'b1;
      inx_d  = 1'b1;
    end else if (e2 > EMAX_E) begin
      word_d = word_ovf;
      ovf_d  = 1'b1;
      inx_d  = 1'b1;
    end else if (!mant[MANT_W-1]) begin
      word_d = {sign_i, {EXPF_W{1'b0}}, mant[FRAC_W-1:0]};
      unf_d  = unf_d || uf_trap_en_i;
    end else begin
      word_d = {sign_i, EXPF_W'(e2 + BIAS_E), mant[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
      inx_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= word_d;
        ovf_o    <= ovf_d;
        unf_o    <= unf_d;
        inx_o    <= inx_d;
      end
    end
  end
endmodule

// File: rtl/dp_round_pack_chk.sv
module dp_round_pack_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               sign_i,
  input logic signed [15:0] exp_i,
  input logic [55:0]        sig_i,
  input logic [1:0]         rmode_i,
  input logic               flush_den_i,
  input logic               uf_trap_en_i,
  input logic               valid_o,
  input logic [63:0]        result_o,
  input logic               ovf_o,
  input logic               unf_o,
  input logic               inx_o
);
  localparam logic [62:0] MAG_INF = 63'h7FF0000000000000;
  localparam logic [62:0] MAG_MAX = 63'h7FEFFFFFFFFFFFFF;

  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_sign_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[63] == $past(sign_i));
  assert_ovf_inx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (inx_o && (result_o[62:0] == MAG_INF || result_o[62:0] == MAG_MAX)));
  assert_ovf_trunc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exp_i > 16'sd1023 && rmode_i == 2'd1) |=> (ovf_o && result_o[62:0] == MAG_MAX));
  assert_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flush_den_i && exp_i < -16'sd1022) |=> (unf_o && inx_o && !ovf_o && result_o[62:1] == '0));
  assert_exact_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sig_i[55] && sig_i[2:0] == 3'd0 && exp_i >= -16'sd1022 && exp_i <= 16'sd1023)
      |=> (!inx_o && !ovf_o));
  assert_no_trap_uf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !uf_trap_en_i && sig_i[55] && sig_i[2:0] == 3'd0 &&
     exp_i >= -16'sd1022 && exp_i <= 16'sd1023) |=> !unf_o);
endmodule

bind dp_round_pack dp_round_pack_chk i_chk (.*);

// File: tb/test_dp_round_pack.sv
`timescale 1ns/1ps
module test_dp_round_pack;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic               sign_i = 1'b0;
  logic signed [15:0] exp_i = '0;
  logic [55:0]        sig_i = '0;
  logic [1:0]         rmode_i = '0;
  logic               flush_den_i = 1'b0;
  logic               uf_trap_en_i = 1'b0;
  logic               valid_o;
  logic [63:0]        result_o;
  logic               ovf_o, unf_o, inx_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  dp_round_pack i_dp_round_pack (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .rmode_i(rmode_i), .flush_den_i(flush_den_i),
    .uf_trap_en_i(uf_trap_en_i), .valid_o(valid_o), .result_o(result_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .inx_o(inx_o)
  );

  function automatic logic [56:0] bump(logic [56:0] x, bit s, bit [1:0] rm);
    if (x[2:0] == 3'd0) return x;
    case (rm)
      2'd0: return x + 57'd3 + {56'd0, x[3]};
      2'd2: return s ? x : x + 57'd8;
      2'd3: return s ? x + 57'd8 : x;
      default: return x;
    endcase
  endfunction

  // returns {word, ovf, unf, inx}
  function automatic logic [66:0] model(bit s, int e, logic [55:0] m, bit [1:0] rm, bit fl, bit te);
    logic [56:0] x, r;
    logic [52:0] mant;
    bit o = 0, u = 0, i = 0, away;
    away = (rm == 2'd2 && !s) || (rm == 2'd3 && s);
    if (fl && e < -1022)
      return {s, away ? 63'd1 : 63'd0, 1'b0, 1'b1, 1'b1};
    x = {1'b0, m};
    if (e < -1022) begin
      r = bump(x, s, rm);
      if (e == -1023 && r[56]) begin
        x = r >> 1;
        x[2:0] = 3'd0;
        i = 1;
      end else begin
        for (int k = 0; k < (-1022 - e) && k < 64; k++) begin
          bit b;
          b = x[0];
          x = x >> 1;
          x[0] = x[0] | b;
        end
      end
      e = -1022;
    end
    if (x[2:0] != 3'd0) begin
      i = 1;
      if (!x[55]) u = 1;
      x = bump(x, s, rm);
      if (x[56]) begin x = x >> 1; e++; end
    end
    mant = x[55:3];
    if (e > 1023)
      return {s, (away || rm == 2'd0) ? 63'h7FF0000000000000 : 63'h7FEFFFFFFFFFFFFF, 1'b1, u, 1'b1};
    if (!mant[52])
      return {s, 11'd0, mant[51:0], 1'b0, u | te, i};
    return {s, 11'(e + 1023), mant[51:0], 1'b0, u, i};
  endfunction

  task automatic chk(string req, logic [66:0] act, logic [66:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got word=%h ovf/unf/inx=%b expected word=%h ovf/unf/inx=%b",
               req, act[66:3], act[2:0], exp_v[66:3], exp_v[2:0]);
    end
  endtask

  task automatic run(string req, bit s, int e, logic [55:0] m, bit [1:0] rm, bit fl, bit te,
                     logic [66:0] want);
    @(negedge clk);
    sign_i = s; exp_i = 16'(e); sig_i = m; rmode_i = rm;
    flush_den_i = fl; uf_trap_en_i = te; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(req, {result_o, ovf_o, unf_o, inx_o}, want);
    n_checks++;
    if (valid_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: valid_o=%b expected 1", valid_o);
    end
  endtask

  task automatic dir(string req, bit s, int e, logic [55:0] m, bit [1:0] rm, bit fl, bit te,
                     logic [63:0] w, bit o, bit u, bit i);
    logic [66:0] mv;
    mv = model(s, e, m, rm, fl, te);
    chk({req, " model"}, mv, {w, o, u, i});
    run(req, s, e, m, rm, fl, te, {w, o, u, i});
  endtask

  localparam logic [55:0] ONE  = 56'h80000000000000;
  localparam logic [55:0] ALL1 = 56'hFFFFFFFFFFFFFF;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {result_o, ovf_o, unf_o, inx_o}, '0);
    n_checks++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R1: reset valid_o=%b expected 0", valid_o); end
    rst_n = 1'b1;

    dir("R2 exact one",  0, 0, ONE, 2'd0, 0, 0, 64'h3FF0000000000000, 0, 0, 0);
    dir("R2 exact neg",  1, 5, ONE | 56'h8, 2'd2, 0, 1, 64'hC040000000000001, 0, 0, 0);
    dir("R3 tie even",   0, 0, ONE | 56'h4, 2'd0, 0, 0, 64'h3FF0000000000000, 0, 0, 1);
    dir("R3 tie odd",    0, 0, ONE | 56'hC, 2'd0, 0, 0, 64'h3FF0000000000002, 0, 0, 1);
    dir("R4 trunc",      0, 0, ONE | 56'h7, 2'd1, 0, 0, 64'h3FF0000000000000, 0, 0, 1);
    dir("R4 up pos",     0, 0, ONE | 56'h1, 2'd2, 0, 0, 64'h3FF0000000000001, 0, 0, 1);
    dir("R4 up neg",     1, 0, ONE | 56'h1, 2'd2, 0, 0, 64'hBFF0000000000000, 0, 0, 1);
    dir("R4 down neg",   1, 0, ONE | 56'h1, 2'd3, 0, 0, 64'hBFF0000000000001, 0, 0, 1);
    dir("R5 carry",      0, 0, ALL1, 2'd0, 0, 0, 64'h4000000000000000, 0, 0, 1);
    dir("R6 ovf near",   0, 1024, ONE, 2'd0, 0, 0, 64'h7FF0000000000000, 1, 0, 1);
    dir("R6 ovf zero",   1, 1024, ONE, 2'd1, 0, 0, 64'hFFEFFFFFFFFFFFFF, 1, 0, 1);
    dir("R6 ovf up neg", 1, 1030, ONE, 2'd2, 0, 0, 64'hFFEFFFFFFFFFFFFF, 1, 0, 1);
    dir("R6 ovf dn neg", 1, 1024, ONE, 2'd3, 0, 0, 64'hFFF0000000000000, 1, 0, 1);
    dir("R6 carry ovf",  0, 1023, ALL1, 2'd0, 0, 0, 64'h7FF0000000000000, 1, 0, 1);
    dir("R7 flush up",   0, -1030, ONE, 2'd2, 1, 0, 64'h0000000000000001, 0, 1, 1);
    dir("R7 flush dn",   1, -1023, ALL1, 2'd3, 1, 0, 64'h8000000000000001, 0, 1, 1);
    dir("R7 flush near", 1, -1100, ONE, 2'd0, 1, 0, 64'h8000000000000000, 0, 1, 1);
    dir("R8 sat near",   0, -3000, ONE, 2'd0, 0, 0, 64'h0000000000000000, 0, 1, 1);
    dir("R8 sat up",     0, -3000, ONE, 2'd2, 0, 0, 64'h0000000000000001, 0, 1, 1);
    dir("R9 edge",       0, -1023, ALL1, 2'd0, 0, 0, 64'h0010000000000000, 0, 0, 1);
    dir("R10 exact den", 0, -1024, ONE, 2'd0, 0, 0, 64'h0004000000000000, 0, 0, 0);
    dir("R10 trap den",  0, -1024, ONE, 2'd0, 0, 1, 64'h0004000000000000, 0, 1, 0);
    dir("R11 tiny inx",  0, -1023, ONE | 56'h1, 2'd1, 0, 0, 64'h0008000000000000, 0, 1, 1);

    @(negedge clk);
    n_checks++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R1: idle valid_o=%b expected 0", valid_o); end

    void'($urandom(32'd7321));
    for (int n = 0; n < 4000; n++) begin
      int e;
      logic [55:0] m;
      bit s, fl, te;
      bit [1:0] rm;
      case ($urandom % 6)
        0: e = -1022 - int'($urandom % 70);
        1: e = -1023;
        2: e = 1021 + int'($urandom % 4);
        3: e = -30000 + int'($urandom % 1000);
        default: e = int'($urandom % 2044) - 1021;
      endcase
      m = {1'b1, 23'($urandom), 32'($urandom)};
      case ($urandom % 4)
        0: m[2:0] = 3'd0;
        1: m = ALL1;
        default: ;
      endcase
      s = 1'($urandom); rm = 2'($urandom);
      fl = ($urandom % 4) == 0; te = 1'($urandom);
      run("R2-R11 random", s, e, m, rm, fl, te, model(s, e, m, rm, fl, te));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule